// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register Block

This block is the software-facing register bank of an Ethernet DMA controller. A processor reaches it over a simple memory-mapped bus. The block turns each byte address into a word index and serves one read or one write per cycle. Most words are plain storage. A few have side effects: the ring base pointers, the transmit poll word, the bus-mode word, the status word and the version word.

The transmit and receive engines talk to the block over single-cycle set pulses and 3-bit process-state codes. The block drives a start pulse toward the transmit engine, a receive-enable level, the two ring base pointers and the two current descriptor pointers. A level-sensitive interrupt line is high while any latched status event is also enabled.

A small bus state machine tracks the last accepted transaction. It has three states:
- ST_IDLE: no request in the previous cycle.
- ST_READ: a read was accepted, so read data is valid.
- ST_WRITE: a write was accepted.

From every state, the next state depends only on the current request:
- IDLE_NEXT: no request, so the machine goes to ST_IDLE.
- READ_NEXT: a read request, so the machine goes to ST_READ.
- WRITE_NEXT: a write request, so the machine goes to ST_WRITE.

Top module: `dma_csr_top`

## Requirements
- R1: After reset, every in-range word reads zero except the version word. The interrupt, transmit poll and receive-enable outputs are low, and all four pointer outputs are zero.
- R2: The word index is the byte address shifted right by two, with the low two address bits ignored. The space holds 1024 words. A read at a word index of 1024 or more returns zero, and a write there changes no state.
- R3: The word at index 0x08 always reads 0x1012, whatever was written to it.
- R4: Writing the status word (index 0x3C5) clears each event bit whose written bit is one and leaves the other event bits unchanged. The event bits are 0, 6, 7, 15 and 16. All other status bits never latch.
- R5: A transmit-done pulse sets status bits 0 and 16. A receive-done pulse sets bits 6 and 16. A receive-no-buffer pulse sets bits 7 and 15. When a set pulse and a software clear hit the same bit in the same cycle, the set wins.
- R6: Status bits 22:20 read the transmit process-state input and bits 19:17 read the receive process-state input. Writes cannot change them.
- R7: A write to the bus-mode word (index 0x3C0) stores the value with bit 0 forced to zero.
- R8: A write to the receive ring base (0x3C3) also loads the current receive pointer (0x3D3). A write to the transmit ring base (0x3C4) also loads the current transmit pointer (0x3D2). All four values are driven on output ports.
- R9: A write to the transmit poll word (0x3C1) stores nothing and raises `tx_poll_o` for exactly the cycle after the write. That word reads zero.
- R10: `irq_o` is high, from the cycle after any write or status update, exactly when some event bit is set in both the status word and the enable word (0x3C7).
- R11: `rx_en_o` follows bit 1 of the control word (0x3C6).
- R12: Read data and `bus_rvalid_o` appear in the cycle after a read request. Any other in-range word returns the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Request valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| bus_rvalid_o | output | 1 | Read data valid |
| tx_done_i | input | 1 | Transmit-done set pulse |
| rx_done_i | input | 1 | Receive-done set pulse |
| rx_nobuf_i | input | 1 | Receive-no-buffer set pulse |
| tx_state_i | input | 3 | Transmit process-state code |
| rx_state_i | input | 3 | Receive process-state code |
| irq_o | output | 1 | Level interrupt |
| tx_poll_o | output | 1 | One-cycle transmit start pulse |
| rx_en_o | output | 1 | Receive enable |
| tx_base_o | output | 32 | Transmit ring base |
| rx_base_o | output | 32 | Receive ring base |
| tx_cur_o | output | 32 | Current transmit descriptor pointer |
| rx_cur_o | output | 32 | Current receive descriptor pointer |

## Verification
Random traffic weighted toward the side-effect words exposes mix-ups between plain storage and the special write rules, such as a missing pointer copy or a stored poll word. Aliased addresses with high bits set separate a correct range check from plain index truncation. Clear writes issued together with set pulses on the same bits separate set-wins from clear-wins. Random enable masks against random event patterns check the interrupt term bit by bit.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned REG_WORDS = 1024;
    localparam int unsigned ADDR_W    = 16;

    // word indices whose behaviour differs from plain storage
    localparam int unsigned IX_VERSION = 'h008;
    localparam int unsigned IX_BUSMODE = 'h3C0;
    localparam int unsigned IX_POLL    = 'h3C1;
    localparam int unsigned IX_RXBASE  = 'h3C3;
    localparam int unsigned IX_TXBASE  = 'h3C4;
    localparam int unsigned IX_STATUS  = 'h3C5;
    localparam int unsigned IX_CTRL    = 'h3C6;
    localparam int unsigned IX_INTEN   = 'h3C7;
    localparam int unsigned IX_TXCUR   = 'h3D2;
    localparam int unsigned IX_RXCUR   = 'h3D3;

    localparam logic [31:0] VERSION_VAL = 32'h0000_1012;

    // status event bit positions
    localparam int unsigned SB_TXDONE = 0;
    localparam int unsigned SB_RXDONE = 6;
    localparam int unsigned SB_NOBUF  = 7;
    localparam int unsigned SB_ABN    = 15;
    localparam int unsigned SB_NRM    = 16;
    localparam int unsigned SB_RXST   = 17;
    localparam int unsigned SB_TXST   = 20;
    localparam int unsigned ST_CODE_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_state_e;

endpackage

// File: rtl/dma_csr_bus_fsm.sv
module dma_csr_bus_fsm
    import dma_csr_pkg::*;
#(
    parameter int unsigned ADDR_W_P = ADDR_W,
    parameter int unsigned DATA_W_P = DATA_W,
    parameter int unsigned IDX_W_P  = $clog2(REG_WORDS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sel_i,
    input  logic                wr_i,
    input  logic [ADDR_W_P-1:0] addr_i,
    input  logic [DATA_W_P-1:0] word_i,
    output logic [IDX_W_P-1:0]  idx_o,
    output logic                hit_o,
    output logic                wr_en_o,
    output logic [DATA_W_P-1:0] rdata_o,
    output logic                rvalid_o
);
    localparam int unsigned LO_BIT = 2;
    localparam int unsigned HI_BIT = IDX_W_P + LO_BIT;

    bus_state_e state_q, state_d;
    logic [DATA_W_P-1:0] rdata_q;

    assign idx_o   = addr_i[HI_BIT-1:LO_BIT];
    assign hit_o   = (addr_i[ADDR_W_P-1:HI_BIT] == '0);
    assign wr_en_o = sel_i && wr_i && hit_o;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_READ, ST_WRITE: begin
                if (!sel_i)    state_d = ST_IDLE;
                else if (wr_i) state_d = ST_WRITE;
                else           state_d = ST_READ;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // read data capture
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              rdata_q <= '0;
        else if (sel_i && !wr_i)  rdata_q <= hit_o ? word_i : '0;
    end

    // outputs
    always_comb begin
        rvalid_o = 1'b0;
        unique case (state_q)
            ST_READ:  rvalid_o = 1'b1;
            ST_IDLE:  rvalid_o = 1'b0;
            ST_WRITE: rvalid_o = 1'b0;
            default:  rvalid_o = 1'b0;
        endcase
        rdata_o = rdata_q;
    end

    AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rvalid_o |-> $past(sel_i && !wr_i)); // R12

    AST_OOR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rvalid_o && $past(!hit_o)) |-> (rdata_o == '0)); // R2

endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status
    import dma_csr_pkg::*;
#(
    parameter int unsigned DATA_W_P = DATA_W
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 clr_en_i,
    input  logic [DATA_W_P-1:0]  clr_mask_i,
    input  logic                 tx_done_i,
    input  logic                 rx_done_i,
    input  logic                 rx_nobuf_i,
    input  logic [ST_CODE_W-1:0] tx_state_i,
    input  logic [ST_CODE_W-1:0] rx_state_i,
    output logic [DATA_W_P-1:0]  events_o,
    output logic [DATA_W_P-1:0]  view_o
);
    localparam logic [DATA_W_P-1:0] ONE = DATA_W_P'(1);
    localparam logic [DATA_W_P-1:0] EV_MASK =
        (ONE << SB_TXDONE) | (ONE << SB_RXDONE) | (ONE << SB_NOBUF) |
        (ONE << SB_ABN)    | (ONE << SB_NRM);

    logic [DATA_W_P-1:0] ev_q, ev_set, ev_clr;

    always_comb begin
        ev_set = '0;
        if (tx_done_i)  ev_set = ev_set | (ONE << SB_TXDONE) | (ONE << SB_NRM);
        if (rx_done_i)  ev_set = ev_set | (ONE << SB_RXDONE) | (ONE << SB_NRM);
        if (rx_nobuf_i) ev_set = ev_set | (ONE << SB_NOBUF)  | (ONE << SB_ABN);
        ev_clr = clr_en_i ? clr_mask_i : '0;
    end

    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ev_q <= '0;
        else         ev_q <= ((ev_q & ~ev_clr) | ev_set) & EV_MASK;
    end

    assign events_o = ev_q;

    always_comb begin
        view_o = ev_q;
        view_o[SB_TXST +: ST_CODE_W] = tx_state_i;
        view_o[SB_RXST +: ST_CODE_W] = rx_state_i;
    end

    AST_TXDONE_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni && tx_done_i) |-> (ev_q[SB_TXDONE] && ev_q[SB_NRM])); // R5

    AST_NOBUF_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni && rx_nobuf_i) |-> (ev_q[SB_NOBUF] && ev_q[SB_ABN])); // R5

    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni && clr_en_i && clr_mask_i[SB_RXDONE] && !rx_done_i)
            |-> !ev_q[SB_RXDONE]); // R4

endmodule

// File: rtl/dma_csr_regfile.sv
module dma_csr_regfile
    import dma_csr_pkg::*;
#(
    parameter int unsigned DATA_W_P = DATA_W,
    parameter int unsigned WORDS_P  = REG_WORDS,
    parameter int unsigned IDX_W_P  = $clog2(REG_WORDS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [IDX_W_P-1:0]  idx_i,
    input  logic [DATA_W_P-1:0] wdata_i,
    output logic [DATA_W_P-1:0] word_o,
    output logic [DATA_W_P-1:0] ctrl_o,
    output logic [DATA_W_P-1:0] inten_o,
    output logic [DATA_W_P-1:0] rx_base_o,
    output logic [DATA_W_P-1:0] tx_base_o,
    output logic [DATA_W_P-1:0] rx_cur_o,
    output logic [DATA_W_P-1:0] tx_cur_o,
    output logic                poll_o
);
    localparam logic [IDX_W_P-1:0] I_BUSMODE = IDX_W_P'(IX_BUSMODE);
    localparam logic [IDX_W_P-1:0] I_POLL    = IDX_W_P'(IX_POLL);
    localparam logic [IDX_W_P-1:0] I_RXBASE  = IDX_W_P'(IX_RXBASE);
    localparam logic [IDX_W_P-1:0] I_TXBASE  = IDX_W_P'(IX_TXBASE);
    localparam logic [IDX_W_P-1:0] I_STATUS  = IDX_W_P'(IX_STATUS);
    localparam logic [IDX_W_P-1:0] I_RXCUR   = IDX_W_P'(IX_RXCUR);
    localparam logic [IDX_W_P-1:0] I_TXCUR   = IDX_W_P'(IX_TXCUR);

    logic [DATA_W_P-1:0] mem_q [WORDS_P];
    logic                poll_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < int'(WORDS_P); i++) mem_q[i] <= '0;
            poll_q <= 1'b0;
        end else begin
            poll_q <= wr_en_i && (idx_i == I_POLL);
            if (wr_en_i) begin
                case (idx_i)
                    I_BUSMODE: mem_q[idx_i] <= wdata_i & ~DATA_W_P'(1);
                    I_POLL:    ;
                    I_STATUS:  ;
                    I_RXBASE: begin
                        mem_q[I_RXBASE] <= wdata_i;
                        mem_q[I_RXCUR]  <= wdata_i;
                    end
                    I_TXBASE: begin
                        mem_q[I_TXBASE] <= wdata_i;
                        mem_q[I_TXCUR]  <= wdata_i;
                    end
                    default:   mem_q[idx_i] <= wdata_i;
                endcase
            end
        end
    end

    assign word_o    = mem_q[idx_i];
    assign ctrl_o    = mem_q[IX_CTRL];
    assign inten_o   = mem_q[IX_INTEN];
    assign rx_base_o = mem_q[IX_RXBASE];
    assign tx_base_o = mem_q[IX_TXBASE];
    assign rx_cur_o  = mem_q[IX_RXCUR];
    assign tx_cur_o  = mem_q[IX_TXCUR];
    assign poll_o    = poll_q;

    AST_RXBASE_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni && wr_en_i && idx_i == I_RXBASE) |-> (rx_cur_o == rx_base_o)); // R8

    AST_TXBASE_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni && wr_en_i && idx_i == I_TXBASE) |-> (tx_cur_o == tx_base_o)); // R8

    AST_BUSMODE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni && wr_en_i && idx_i == I_BUSMODE) |-> !mem_q[IX_BUSMODE][0]); // R7

endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
    import dma_csr_pkg::*;
#(
    parameter int unsigned ADDR_W_P = ADDR_W,
    parameter int unsigned DATA_W_P = DATA_W,
    parameter int unsigned WORDS_P  = REG_WORDS
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W_P-1:0]  bus_addr_i,
    input  logic [DATA_W_P-1:0]  bus_wdata_i,
    output logic [DATA_W_P-1:0]  bus_rdata_o,
    output logic                 bus_rvalid_o,
    input  logic                 tx_done_i,
    input  logic                 rx_done_i,
    input  logic                 rx_nobuf_i,
    input  logic [ST_CODE_W-1:0] tx_state_i,
    input  logic [ST_CODE_W-1:0] rx_state_i,
    output logic                 irq_o,
    output logic                 tx_poll_o,
    output logic                 rx_en_o,
    output logic [DATA_W_P-1:0]  tx_base_o,
    output logic [DATA_W_P-1:0]  rx_base_o,
    output logic [DATA_W_P-1:0]  tx_cur_o,
    output logic [DATA_W_P-1:0]  rx_cur_o
);
    localparam int unsigned IDX_W_L = $clog2(WORDS_P);
    localparam logic [IDX_W_L-1:0] I_VERSION = IDX_W_L'(IX_VERSION);
    localparam logic [IDX_W_L-1:0] I_STATUS  = IDX_W_L'(IX_STATUS);
    localparam logic [IDX_W_L-1:0] I_POLL    = IDX_W_L'(IX_POLL);

    logic [IDX_W_L-1:0]  idx;
    logic                hit, wr_en;
    logic [DATA_W_P-1:0] rf_word, rd_word, ev, view, ctrl, inten;

    dma_csr_bus_fsm #(.ADDR_W_P(ADDR_W_P), .DATA_W_P(DATA_W_P), .IDX_W_P(IDX_W_L)) i_bus (
        .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(bus_sel_i), .wr_i(bus_wr_i),
        .addr_i(bus_addr_i), .word_i(rd_word), .idx_o(idx), .hit_o(hit),
        .wr_en_o(wr_en), .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o)
    );

    dma_csr_status #(.DATA_W_P(DATA_W_P)) i_stat (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .clr_en_i(wr_en && idx == I_STATUS), .clr_mask_i(bus_wdata_i),
        .tx_done_i(tx_done_i), .rx_done_i(rx_done_i), .rx_nobuf_i(rx_nobuf_i),
        .tx_state_i(tx_state_i), .rx_state_i(rx_state_i),
        .events_o(ev), .view_o(view)
    );

    dma_csr_regfile #(.DATA_W_P(DATA_W_P), .WORDS_P(WORDS_P), .IDX_W_P(IDX_W_L)) i_rf (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .idx_i(idx),
        .wdata_i(bus_wdata_i), .word_o(rf_word), .ctrl_o(ctrl), .inten_o(inten),
        .rx_base_o(rx_base_o), .tx_base_o(tx_base_o), .rx_cur_o(rx_cur_o),
        .tx_cur_o(tx_cur_o), .poll_o(tx_poll_o)
    );

    always_comb begin
        if (idx == I_VERSION)     rd_word = DATA_W_P'(VERSION_VAL);
        else if (idx == I_STATUS) rd_word = view;
        else                      rd_word = rf_word;
    end

    assign irq_o   = |(ev & inten);
    assign rx_en_o = ctrl[1];

    AST_POLL_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_poll_o |-> $past(bus_sel_i && bus_wr_i && hit && idx == I_POLL)); // R9

    AST_FULL_CLEAR_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni && wr_en && idx == I_STATUS && (&bus_wdata_i)
              && !tx_done_i && !rx_done_i && !rx_nobuf_i) |-> !irq_o); // R10

    AST_VERSION_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni && bus_sel_i && !bus_wr_i && hit && idx == I_VERSION)
            |-> (bus_rdata_o == DATA_W_P'(VERSION_VAL))); // R3

endmodule

// File: tb/test_dma_csr_top.sv
module test_dma_csr_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sel = 0, wr = 0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        rvalid, td = 0, rd = 0, nb = 0, irq, poll, rxen;
    logic [2:0]  ts = '0, rs = '0;
    logic [31:0] txb, rxb, txc, rxc;

    int total = 0, bad = 0;
    logic [31:0] mem_m [1024];
    logic [31:0] st_m;
    bit done = 0;

    dma_csr_top i_dma_csr_top (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .bus_rvalid_o(rvalid), .tx_done_i(td), .rx_done_i(rd), .rx_nobuf_i(nb),
        .tx_state_i(ts), .rx_state_i(rs), .irq_o(irq), .tx_poll_o(poll),
        .rx_en_o(rxen), .tx_base_o(txb), .rx_base_o(rxb), .tx_cur_o(txc),
        .rx_cur_o(rxc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] view_m(logic [2:0] t, logic [2:0] r);
        return st_m | (32'(t) << 20) | (32'(r) << 17);
    endfunction

    function automatic logic [31:0] read_m(logic [15:0] a, logic [2:0] t, logic [2:0] r);
        logic [9:0] ix = a[11:2];
        if (a[15:12] != 0) return 32'h0;            // R2
        if (ix == 10'h008) return 32'h0000_1012;    // R3
        if (ix == 10'h3C5) return view_m(t, r);     // R6
        return mem_m[ix];
    endfunction

    function automatic logic [31:0] set_m(logic a, logic b, logic c);
        logic [31:0] s = '0;
        if (a) s |= 32'h0001_0001;
        if (b) s |= 32'h0001_0040;
        if (c) s |= 32'h0000_8080;
        return s;
    endfunction

    task automatic step(logic s, logic w, logic [15:0] a, logic [31:0] d,
                        logic pt, logic pr, logic pn, logic [2:0] t, logic [2:0] r);
        logic [31:0] exp_rd;
        logic [9:0]  ix;
        logic        hitw;
        @(negedge clk);
        sel = s; wr = w; addr = a; wdata = d; td = pt; rd = pr; nb = pn; ts = t; rs = r;
        exp_rd = read_m(a, t, r);
        ix = a[11:2];
        hitw = s && w && (a[15:12] == 0);
        @(posedge clk);
        st_m = (st_m & ~((hitw && ix == 10'h3C5) ? d : 32'h0)) | set_m(pt, pr, pn);
        if (hitw) begin
            case (ix)
                10'h3C0: mem_m[ix] = d & ~32'h1;
                10'h3C1, 10'h3C5: ;
                10'h3C3: begin mem_m[ix] = d; mem_m[10'h3D3] = d; end
                10'h3C4: begin mem_m[ix] = d; mem_m[10'h3D2] = d; end
                default: mem_m[ix] = d;
            endcase
        end
        #1;
        if (s && !w) begin
            chk("R12 rvalid", 32'(rvalid), 32'h1);
            chk("R2/R3/R4/R6/R12 rdata", rdata, exp_rd);
        end else chk("R12 rvalid low", 32'(rvalid), 32'h0);
        chk("R9 tx_poll", 32'(poll), 32'(hitw && ix == 10'h3C1));
        chk("R10 irq", 32'(irq), 32'(|(st_m & mem_m[10'h3C7])));
        chk("R11 rx_en", 32'(rxen), 32'(mem_m[10'h3C6][1]));
        chk("R8 rx_base", rxb, mem_m[10'h3C3]);
        chk("R8 tx_base", txb, mem_m[10'h3C4]);
        chk("R8 rx_cur", rxc, mem_m[10'h3D3]);
        chk("R8 tx_cur", txc, mem_m[10'h3D2]);
    endtask

    task automatic rd_w(logic [9:0] ix);
        step(1, 0, {4'h0, ix, 2'b00}, 32'h0, 0, 0, 0, ts, rs);
    endtask
    task automatic wr_w(logic [9:0] ix, logic [31:0] d);
        step(1, 1, {4'h0, ix, 2'b00}, d, 0, 0, 0, ts, rs);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) mem_m[i] = '0;
        st_m = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state at the ports
        chk("R1 irq", 32'(irq), 0); chk("R1 poll", 32'(poll), 0);
        chk("R1 rx_en", 32'(rxen), 0); chk("R1 tx_cur", txc, 0);
        @(negedge clk); rst_n = 1'b1;
        rd_w(10'h3C6); rd_w(10'h3C5); rd_w(10'h000); rd_w(10'h3D2);
        rd_w(10'h008);                                   // R3 after reset
        // R3: version ignores writes
        wr_w(10'h008, 32'hFFFF_FFFF); rd_w(10'h008);
        // R7: bus mode bit 0
        wr_w(10'h3C0, 32'hA5A5_A5A5); rd_w(10'h3C0);
        // R8: base loads current pointer
        wr_w(10'h3C3, 32'h1000_0040); wr_w(10'h3C4, 32'h2000_0080);
        wr_w(10'h3D2, 32'h2000_0100); rd_w(10'h3D2); rd_w(10'h3D3);
        // R9: poll pulse, word reads zero
        wr_w(10'h3C1, 32'hFFFF_FFFF); rd_w(10'h3C1);
        wr_w(10'h3C1, 32'h1); wr_w(10'h3C1, 32'h1);
        // R11
        wr_w(10'h3C6, 32'h2); wr_w(10'h3C6, 32'h0);
        // R5, R10: events, enable, set wins over clear
        wr_w(10'h3C7, 32'h0001_80C1);
        step(1, 0, 16'h0F14, 0, 1, 1, 1, 3'd5, 3'd2);
        rd_w(10'h3C5);
        step(1, 1, 16'h0F14, 32'hFFFF_FFFF, 1, 0, 0, 3'd1, 3'd6); // R5 set wins
        rd_w(10'h3C5);
        wr_w(10'h3C5, 32'h0000_0040);                  // R4 partial clear
        wr_w(10'h3C5, 32'hFFFF_FFFF); rd_w(10'h3C5);   // R4 full clear, R6 fields
        // R2: aliased out-of-range write/read; low bits ignored
        wr_w(10'h123, 32'h1111_2222);
        step(1, 1, 16'h148C, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
        step(1, 0, 16'h148C, 0, 0, 0, 0, 0, 0);
        step(1, 0, 16'h048F, 0, 0, 0, 0, 0, 0);
        step(1, 1, 16'hFF0C, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        rd_w(10'h3C3);
        // random traffic
        for (int n = 0; n < N_RAND; n++) begin
            int unsigned pick = $urandom_range(0, 99);
            logic [9:0]  ix;
            logic [15:0] a;
            case ($urandom_range(0, 9))
                0: ix = 10'h008; 1: ix = 10'h3C0; 2: ix = 10'h3C1;
                3: ix = 10'h3C3; 4: ix = 10'h3C4; 5: ix = 10'h3C5;
                6: ix = 10'h3C6; 7: ix = 10'h3C7; 8: ix = 10'h3D2;
                default: ix = 10'($urandom);
            endcase
            a = {(pick < 12) ? 4'($urandom_range(1, 15)) : 4'h0, ix, 2'($urandom)};
            step($urandom_range(0, 9) != 0, $urandom_range(0, 1) == 1, a,
                 (ix == 10'h3C5 && $urandom_range(0, 1) == 1) ? 32'hFFFF_FFFF : $urandom,
                 $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
                 $urandom_range(0, 7) == 0, 3'($urandom), 3'($urandom));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule